// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Sequencer

This block is a host-side controller that wipes an entire serial NOR flash after one start pulse. It is the SPI master in mode 0: it drives the chip-select (active low), the serial clock and the master-out data line, and it samples the master-in line. On a start it sends a write-enable command in a frame of its own. It then sends the whole-array erase opcode in a second frame, and raises chip-select straight after the eighth bit because the device only begins erasing on that rising edge. It then opens a third frame holding the read-status opcode and keeps chip-select low while the device streams status bytes. Bit 0 of each byte is tested, and the frame ends as soon as that bit reads 0.

A byte counter bounds the wait. If every one of `MAX_POLL` status bytes reports busy, the sequencer releases chip-select, sets a sticky error flag and returns to idle. A completed erase gives a one-cycle done pulse. A clock divider sets the serial clock half-period, and a parameter sets the minimum chip-select high time between frames.

The state machine has the states IDLE, PRE_GAP, WREN, GAP_WE, ERASE, GAP_ER, RDCMD and POLL. The transitions are:
- IDLE→PRE_GAP on start.
- PRE_GAP→WREN, GAP_WE→ERASE and GAP_ER→RDCMD when the gap count expires.
- WREN→GAP_WE, ERASE→GAP_ER and RDCMD→POLL when a byte completes.
- POLL→POLL when a busy byte arrives under the limit.
- POLL→IDLE when a ready byte arrives (done) or on the last allowed busy byte (timeout).

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, and busy, done and error are all low.
- R2: A start in idle first sends the write-enable opcode 0x06 as a frame of exactly 8 bits, most significant bit first, closed by chip-select going high.
- R3: The second frame carries the erase opcode `ERASE_OP` (default 0xC7; 0x60 may be chosen) as exactly 8 bits, most significant bit first, and chip-select rises right after the eighth bit.
- R4: Chip-select stays high for at least `CE_HIGH_CYC` clock cycles before every falling edge.
- R5: The serial clock idles low, is low whenever chip-select is high, and stays high for exactly `HALF_DIV` cycles per pulse. The master-out line only changes while the serial clock is low, and the master-in line is sampled on the rising edge.
- R6: The third frame starts with the read-status opcode 0x05 and keeps chip-select low through consecutive status bytes. BUSY is bit 0, which is the last bit of each byte. The frame ends after the first byte whose bit 0 is 0, so a device that is busy for N bytes gives N+1 status bytes.
- R7: `busy_o` is high from the cycle after an accepted start until the operation ends. A successful end produces a `done_o` pulse exactly one cycle long, with `busy_o` low in that cycle.
- R8: If `MAX_POLL` status bytes all show BUSY=1, chip-select is released after the last of them, `err_o` is set and stays set, and no done pulse is produced.
- R9: An accepted start clears `err_o` in the following cycle.
- R10: A start while `busy_o` is high is ignored: the operation still uses exactly three frames and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| miso_i | input | 1 | Serial data from the flash |
| ce_n_o | output | 1 | Flash chip-select, active low |
| sck_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data to the flash |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky timeout flag |

## Verification
The hardest situations to reach from the ports are the edges of the poll budget. One is a device that becomes ready on the very last allowed status byte. The other is a device still busy on that byte. Telling them apart needs a flash model that counts status bytes inside one long frame. The bench model answers the read-status frame with a stream whose BUSY bit stays high for a programmed number of bytes. The stimulus table sets that number to 0, 1, 3, `MAX_POLL`-1, `MAX_POLL` and beyond, so the last vectors finish exactly on the boundary and just past it.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_DUMMY     = 8'h00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_GAP,
        S_WREN,
        S_GAP_WE,
        S_ERASE,
        S_GAP_ER,
        S_RDCMD,
        S_POLL
    } seq_state_t;

endpackage

// File: rtl/fes_sck_gen.sv
module fes_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/fes_byte_shifter.sv
module fes_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       active_o,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic       last_bit_o
);
    logic       active_q;
    logic       sck_q;
    logic [7:0] sh_q;
    logic [2:0] bit_q;
    logic       done_q;
    logic       smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            sh_q     <= '0;
            bit_q    <= '0;
            done_q   <= 1'b0;
            smp_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                active_q <= 1'b1;
                sck_q    <= 1'b0;
                sh_q     <= tx_i;
                bit_q    <= '0;
            end else if (active_q && tick_i) begin
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    smp_q <= miso_i;
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign active_o   = active_q;
    assign sck_o      = sck_q;
    assign mosi_o     = sh_q[7];
    assign done_o     = done_q;
    assign last_bit_o = smp_q;

endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
    import fes_pkg::*;
#(
    parameter logic [7:0] ERASE_OP    = 8'hC7,
    parameter int         CE_HIGH_CYC = 4,
    parameter int         MAX_POLL    = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_done_i,
    input  logic       busy_bit_i,
    output logic       load_o,
    output logic [7:0] tx_o,
    output logic       ce_n_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int GW = $clog2(CE_HIGH_CYC + 1);
    localparam int PW = $clog2(MAX_POLL + 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(CE_HIGH_CYC - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLL - 1);

    seq_state_t    state_q, nxt;
    logic [GW-1:0] gap_q;
    logic [PW-1:0] poll_q;
    logic          gap_done;
    logic          in_gap;
    logic          finish_ok;
    logic          finish_to;
    logic          ce_n_q, done_q, err_q;

    assign in_gap   = (state_q == S_PRE_GAP) || (state_q == S_GAP_WE) ||
                      (state_q == S_GAP_ER);
    assign gap_done = in_gap && (gap_q == GAP_LAST);

    // next-state and byte-launch logic
    always_comb begin
        nxt       = state_q;
        load_o    = 1'b0;
        tx_o      = OP_DUMMY;
        finish_ok = 1'b0;
        finish_to = 1'b0;
        unique case (state_q)
            S_IDLE: if (start_i) nxt = S_PRE_GAP;
            S_PRE_GAP: if (gap_done) begin
                nxt    = S_WREN;
                load_o = 1'b1;
                tx_o   = OP_WR_ENABLE;
            end
            S_WREN: if (byte_done_i) nxt = S_GAP_WE;
            S_GAP_WE: if (gap_done) begin
                nxt    = S_ERASE;
                load_o = 1'b1;
                tx_o   = ERASE_OP;
            end
            S_ERASE: if (byte_done_i) nxt = S_GAP_ER;
            S_GAP_ER: if (gap_done) begin
                nxt    = S_RDCMD;
                load_o = 1'b1;
                tx_o   = OP_RD_STATUS;
            end
            S_RDCMD: if (byte_done_i) begin
                nxt    = S_POLL;
                load_o = 1'b1;
            end
            S_POLL: if (byte_done_i) begin
                if (!busy_bit_i) begin
                    nxt       = S_IDLE;
                    finish_ok = 1'b1;
                end else if (poll_q == POLL_LAST) begin
                    nxt       = S_IDLE;
                    finish_to = 1'b1;
                end else begin
                    load_o = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register with gap and poll counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            gap_q   <= '0;
            poll_q  <= '0;
        end else begin
            state_q <= nxt;
            if (in_gap && nxt == state_q) gap_q <= gap_q + 1'b1;
            else                          gap_q <= '0;
            if (state_q == S_RDCMD)                  poll_q <= '0;
            else if (state_q == S_POLL && byte_done_i) poll_q <= poll_q + 1'b1;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            ce_n_q <= !((nxt == S_WREN) || (nxt == S_ERASE) ||
                        (nxt == S_RDCMD) || (nxt == S_POLL));
            done_q <= finish_ok;
            if (state_q == S_IDLE && start_i) err_q <= 1'b0;
            else if (finish_to)               err_q <= 1'b1;
        end
    end

    assign ce_n_o = ce_n_q;
    assign busy_o = (state_q != S_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
    parameter logic [7:0] ERASE_OP    = 8'hC7,
    parameter int         HALF_DIV    = 2,
    parameter int         CE_HIGH_CYC = 4,
    parameter int         MAX_POLL    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic miso_i,
    output logic ce_n_o,
    output logic sck_o,
    output logic mosi_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    logic       tick;
    logic       active;
    logic       load;
    logic [7:0] tx;
    logic       byte_done;
    logic       busy_bit;

    fes_sck_gen #(.HALF_DIV(HALF_DIV)) sck_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (active),
        .tick_o (tick)
    );

    fes_byte_shifter shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .tx_i       (tx),
        .miso_i     (miso_i),
        .active_o   (active),
        .sck_o      (sck_o),
        .mosi_o     (mosi_o),
        .done_o     (byte_done),
        .last_bit_o (busy_bit)
    );

    fes_ctrl #(
        .ERASE_OP    (ERASE_OP),
        .CE_HIGH_CYC (CE_HIGH_CYC),
        .MAX_POLL    (MAX_POLL)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_done_i (byte_done),
        .busy_bit_i  (busy_bit),
        .load_o      (load),
        .tx_o        (tx),
        .ce_n_o      (ce_n_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int CE_HIGH_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n_o,
    input logic sck_o,
    input logic mosi_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt <= '0;
        else if (!ce_n_o)      hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !ce_n_o);

    assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    assert_ce_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n_o) |-> (hi_cnt >= 16'(CE_HIGH_CYC)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !err_o && ce_n_o));

    assert_err_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (ce_n_o && !busy_o));

    assert_idle_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ce_n_o);

endmodule

bind flash_erase_seq fes_checker #(.CE_HIGH_CYC(CE_HIGH_CYC)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n_o (ce_n_o),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .err_o  (err_o)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

    localparam int HALF_DIV    = 2;
    localparam int CE_HIGH_CYC = 3;
    localparam int MAX_POLL    = 6;
    localparam int NVEC        = 6;
    localparam int VEC_BUSY [NVEC] = '{0, 1, 3, 5, 6, 9};
    localparam bit VEC_ERR  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic miso_i = 1'b0;
    logic ce_n_o, sck_o, mosi_o, busy_o, done_o, err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    flash_erase_seq #(
        .ERASE_OP    (8'hC7),
        .HALF_DIV    (HALF_DIV),
        .CE_HIGH_CYC (CE_HIGH_CYC),
        .MAX_POLL    (MAX_POLL)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .miso_i  (miso_i),
        .ce_n_o  (ce_n_o),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    // flash model
    int         m_busy_bytes = 0;
    int         m_bits = 0;
    logic [7:0] m_shift = '0;
    logic [7:0] m_cmd = '0;
    int         nframes = 0;
    logic [7:0] f_cmd  [8];
    int         f_bits [8];

    always @(posedge sck_o) begin
        if (!ce_n_o) begin
            m_shift = {m_shift[6:0], mosi_o};
            m_bits  = m_bits + 1;
            if (m_bits == 8) m_cmd = m_shift;
        end
    end

    always @(negedge sck_o) begin
        if (!ce_n_o && m_bits >= 8 && m_cmd == 8'h05) begin
            int idx;
            idx = m_bits - 8;
            if ((idx % 8) == 7) miso_i = ((idx / 8) < m_busy_bytes);
            else                miso_i = 1'b0;
        end
    end

    always @(posedge ce_n_o) begin
        if (nframes < 8) begin
            f_cmd[nframes]  = m_cmd;
            f_bits[nframes] = m_bits;
        end
        nframes = nframes + 1;
        m_bits  = 0;
        m_cmd   = '0;
        miso_i  = 1'b0;
    end

    // timing monitors sampled away from the active edge
    int hi_run = 0, min_gap = 1000;
    int sck_run = 0, sck_min = 1000, sck_max = 0;
    int done_cnt = 0;
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (ce_n_o) hi_run = hi_run + 1;
        else if (hi_run > 0) begin
            if (hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
        if (sck_o) sck_run = sck_run + 1;
        else if (sck_run > 0) begin
            if (sck_run < sck_min) sck_min = sck_run;
            if (sck_run > sck_max) sck_max = sck_run;
            sck_run = 0;
        end
        if (done_o) done_cnt = done_cnt + 1;
        if (cycles > 100000) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input int busy_n, input bit exp_err, input bit poke);
        int  waitc;
        bit  got_done, got_err;
        int  exp_sb;
        m_busy_bytes = busy_n;
        nframes  = 0;
        min_gap  = 1000;
        sck_min  = 1000;
        sck_max  = 0;
        done_cnt = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
        check(err_o == 1'b0, "R9 err cleared by start", err_o, 0);
        waitc = 0;
        got_done = 1'b0;
        got_err  = 1'b0;
        while (!got_done && !got_err && waitc < 5000) begin
            @(negedge clk);
            waitc = waitc + 1;
            if (poke && waitc == 40) start_i = 1'b1;
            if (poke && waitc == 41) start_i = 1'b0;
            got_done = done_o;
            got_err  = err_o;
        end
        check(got_err == exp_err, "R8 timeout outcome", got_err, exp_err);
        check(got_done == !exp_err, "R6 done outcome", got_done, !exp_err);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        check(err_o == exp_err, "R8 err sticky", err_o, exp_err);
        check(busy_o == 1'b0, "R7 busy low after end", busy_o, 0);
        repeat (8) @(negedge clk);
        check(done_cnt == (exp_err ? 0 : 1), "R10 single done pulse", done_cnt, exp_err ? 0 : 1);
        check(nframes == 3, "R10 three frames", nframes, 3);
        check(f_cmd[0] == 8'h06 && f_bits[0] == 8, "R2 wren frame", {f_cmd[0], 8'(f_bits[0])}, 16'h0608);
        check(f_cmd[1] == 8'hC7 && f_bits[1] == 8, "R3 erase frame", {f_cmd[1], 8'(f_bits[1])}, 16'hC708);
        exp_sb = exp_err ? MAX_POLL : busy_n + 1;
        check(f_cmd[2] == 8'h05, "R6 status opcode", f_cmd[2], 8'h05);
        check(f_bits[2] == 8 + 8 * exp_sb, "R6 status byte count", f_bits[2], 8 + 8 * exp_sb);
        check(min_gap >= CE_HIGH_CYC, "R4 ce high gap", min_gap, CE_HIGH_CYC);
        check(sck_min == HALF_DIV && sck_max == HALF_DIV, "R5 sck high width", sck_max, HALF_DIV);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ce_n_o == 1'b1, "R1 ce high", ce_n_o, 1);
        check(sck_o == 1'b0, "R1 sck low", sck_o, 0);
        check({busy_o, done_o, err_o} == 3'b000, "R1 flags low", {busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ce_n_o == 1'b1 && busy_o == 1'b0, "R1 idle after reset", {ce_n_o, busy_o}, 2);

        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC_BUSY[v], VEC_ERR[v], 1'b0);
        end

        // last vector left err set: a fresh start must clear it (R9) and run normally
        check(err_o == 1'b1, "R9 err held before start", err_o, 1);
        run_op(2, 1'b0, 1'b0);

        // R10: start pulse while busy is ignored
        run_op(4, 1'b0, 1'b1);
        // boundary: ready on the last allowed byte after an ignored start
        run_op(MAX_POLL - 1, 1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule